// File: doc/BRIEF.md
# Folded Symmetric Matched Filter for Binary Phase Keying

This block is the receive-side matched filter of a simple binary phase-keyed receiver. The transmitter maps each bit to a signed level, inserts zero samples to reach several samples per symbol, and shapes the result with a square-root raised cosine pulse (rolloff 0.5). This filter applies the same response to the received sample stream, so the overall chain has a raised cosine response. It accepts one signed sample whenever its input strobe is high. For each such sample it returns one filtered sample a fixed number of cycles later.

The impulse response is symmetric. Each pair of delay-line samples that sees the same coefficient is therefore summed first and multiplied once. The odd centre tap is multiplied on its own. All products are summed at full precision. The sum is rounded once, and clamped to the output range instead of wrapping. The coefficients are a synthesis-time parameter array holding only the unique half of the response. Symbol timing and the bit decision belong to later stages.

Top module: `mf_fir_top`

## Requirements
- R1: With default parameters the filter has 49 taps. A single input of value 16384 (1.0) with zero history yields, on its k-th output (k = 0..48), the value (c[k] + 1) >>> 1. Here c[k] = COEFS[k] for k < 25 and c[k] = COEFS[48-k] otherwise.
- R2: Every output equals the full 49-term convolution sum of c[k]·x[n-k], rounded and saturated as in R3 and R4. Because of the folding, the impulse response is mirror-symmetric: output k equals output 48-k.
- R3: The input is 16-bit two's complement with 14 fraction bits. The coefficients are 16-bit with 15 fraction bits. The output is 18-bit two's complement with 14 fraction bits. The exact sum (29 fraction bits) is rounded by adding 2^14 and shifting right arithmetically by 15.
- R4: A rounded result above 131071 is output as 131071, and one below -131072 is output as -131072. The output never changes sign relative to the exact sum.
- R5: `outValid` is high for exactly one cycle for each accepted input. It rises after the fourth rising edge that follows the edge that sampled `inValid` high.
- R6: The delay line moves only on edges where `inValid` is high. Idle cycles between inputs leave every later output unchanged, and `outData` holds its value while `outValid` is low.
- R7: A synchronous `rst` clears the delay line, the pipeline and the output, so `outValid` = 0 and `outData` = 0. Inputs in flight are dropped. The first outputs after reset are computed from an all-zero history.
- R8: A stream of random bits, each mapped as bit 1 → +16384 and bit 0 → -16384 and followed by three zero samples, produces outputs that match R2 bit-exactly. This holds both when samples arrive back-to-back and when idle cycles are inserted between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input sample strobe |
| inData | input | 16 | Input sample, signed, 14 fraction bits |
| outValid | output | 1 | Output sample strobe |
| outData | output | 18 | Filtered sample, signed, 14 fraction bits |

## Verification
A corrupted delay-line word appears in the outputs four cycles after the next accepted sample. It keeps disturbing up to 49 consecutive outputs until it shifts out of the line. A wrong coefficient, or a wrong pairing in the pre-adders, makes the impulse response asymmetric or off by a large amount, so it shows within the 49 outputs that follow a single impulse. A fault in the valid pipeline shows at once: an output either arrives in the wrong cycle or has no matching input. A wrap in the final stage flips the sign of a full-scale result, so the sign-matched full-scale inputs expose it on the very output they produce.

// File: rtl/mf_pkg.sv
package mf_pkg;

  // Strobes from the control path: one enable per pipeline register bank.
  typedef struct packed {
    logic shiftEn;   // advance delay line
    logic preEn;     // capture pair sums
    logic mulEn;     // capture products
    logic sumEn;     // capture accumulated sum
    logic outEn;     // capture rounded, clamped output
  } stageStrobes_t;

  localparam int DEF_TAPS   = 49;
  localparam int DEF_COEF_W = 16;
  localparam int DEF_UNIQ   = (DEF_TAPS + 1) / 2;

  // Unique half of a square-root raised cosine response (rolloff 0.5,
  // four samples per symbol), outermost tap first, centre tap last.
  localparam logic signed [DEF_COEF_W-1:0] DEF_COEFS [DEF_UNIQ] = '{
    16'sd125,   16'sd48,    -16'sd116,  -16'sd167,  -16'sd19,
    16'sd167,   16'sd141,   -16'sd109,  -16'sd286,  -16'sd109,
    16'sd302,   16'sd466,   16'sd87,    -16'sd466,  -16'sd424,
    16'sd437,   16'sd1198,  16'sd437,   -16'sd2119, -16'sd4431,
    -16'sd2996, 16'sd4431,  16'sd16345, 16'sd27536, 16'sd32112
  };

endpackage

// File: rtl/mf_ctrl.sv
module mf_ctrl
  import mf_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          inValid,
  output stageStrobes_t strobes,
  output logic          outValid
);

  localparam int PIPE_DEPTH = 4;

  logic [PIPE_DEPTH-1:0] validPipe;
  logic [2:0]            warmCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      validPipe <= '0;
      outValid  <= 1'b0;
    end else begin
      validPipe <= {validPipe[PIPE_DEPTH-2:0], inValid};
      outValid  <= validPipe[PIPE_DEPTH-1];
    end
  end

  always_comb begin
    strobes.shiftEn = inValid;
    strobes.preEn   = validPipe[0];
    strobes.mulEn   = validPipe[1];
    strobes.sumEn   = validPipe[2];
    strobes.outEn   = validPipe[3];
  end

  // Cycles since reset, used only to keep the latency check inside history.
  always_ff @(posedge clk) begin
    if (rst)                warmCnt <= '0;
    else if (warmCnt != 3'd7) warmCnt <= warmCnt + 3'd1;
  end

  // R5: output strobe is the input strobe delayed by the pipeline
  assert_valid_latency_R5: assert property (@(posedge clk) disable iff (rst)
    (warmCnt >= 3'd5) |-> (outValid == $past(inValid, 5)));

  // R5: stage enables are never active out of order after reset
  assert_first_stage_R5: assert property (@(posedge clk) disable iff (rst)
    strobes.shiftEn |=> strobes.preEn);

endmodule

// File: rtl/mf_datapath.sv
module mf_datapath
  import mf_pkg::*;
#(
  parameter int NUM_TAPS  = 49,
  parameter int IN_W      = 16,
  parameter int IN_FRAC   = 14,
  parameter int COEF_W    = 16,
  parameter int COEF_FRAC = 15,
  parameter int OUT_W     = 18,
  parameter int OUT_FRAC  = 14,
  parameter logic signed [COEF_W-1:0] COEFS [(NUM_TAPS+1)/2] = DEF_COEFS
) (
  input  logic                    clk,
  input  logic                    rst,
  input  stageStrobes_t           strobes,
  input  logic signed [IN_W-1:0]  inData,
  output logic signed [OUT_W-1:0] outData
);

  localparam int NUM_PAIRS = NUM_TAPS / 2;
  localparam bit HAS_MID   = (NUM_TAPS % 2) == 1;
  localparam int NUM_UNIQ  = (NUM_TAPS + 1) / 2;
  localparam int PRE_W     = IN_W + 1;
  localparam int PROD_W    = PRE_W + COEF_W;
  localparam int ACC_W     = PROD_W + $clog2(NUM_UNIQ);
  localparam int SHIFT     = IN_FRAC + COEF_FRAC - OUT_FRAC;
  localparam int RND_W     = ACC_W + 1;

  localparam logic signed [RND_W-1:0] RND_HALF = RND_W'(1) <<< (SHIFT - 1);
  localparam logic signed [RND_W-1:0] OUT_MAX  = RND_W'((1 <<< (OUT_W - 1)) - 1);
  localparam logic signed [RND_W-1:0] OUT_MIN  = ~OUT_MAX;

  logic signed [IN_W-1:0]   taps    [NUM_TAPS];
  logic signed [PRE_W-1:0]  preNext [NUM_UNIQ];
  logic signed [PRE_W-1:0]  preSum  [NUM_UNIQ];
  logic signed [PROD_W-1:0] prodNext[NUM_UNIQ];
  logic signed [PROD_W-1:0] prodReg [NUM_UNIQ];
  logic signed [ACC_W-1:0]  accNext;
  logic signed [ACC_W-1:0]  accSum;
  logic signed [RND_W-1:0]  rndSum;
  logic signed [RND_W-1:0]  scaled;
  logic signed [OUT_W-1:0]  clampNext;

  // Delay line
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_TAPS; i++) taps[i] <= '0;
    end else if (strobes.shiftEn) begin
      taps[0] <= inData;
      for (int i = 1; i < NUM_TAPS; i++) taps[i] <= taps[i-1];
    end
  end

  // Pre-adders: mirrored taps summed; unpaired centre tap passed through
  always_comb begin
    for (int p = 0; p < NUM_UNIQ; p++) begin
      if (HAS_MID && p == NUM_PAIRS)
        preNext[p] = PRE_W'(taps[p]);
      else
        preNext[p] = PRE_W'(taps[p]) + PRE_W'(taps[NUM_TAPS-1-p]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NUM_UNIQ; p++) preSum[p] <= '0;
    end else if (strobes.preEn) begin
      for (int p = 0; p < NUM_UNIQ; p++) preSum[p] <= preNext[p];
    end
  end

  // One multiplier per unique coefficient
  for (genvar p = 0; p < NUM_UNIQ; p++) begin : g_mul
    localparam logic signed [COEF_W-1:0] COEF_P = COEFS[p];
    assign prodNext[p] = PROD_W'(preSum[p]) * PROD_W'(COEF_P);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NUM_UNIQ; p++) prodReg[p] <= '0;
    end else if (strobes.mulEn) begin
      for (int p = 0; p < NUM_UNIQ; p++) prodReg[p] <= prodNext[p];
    end
  end

  // Full-precision sum of all products
  always_comb begin
    accNext = '0;
    for (int p = 0; p < NUM_UNIQ; p++) accNext = accNext + ACC_W'(prodReg[p]);
  end

  always_ff @(posedge clk) begin
    if (rst)                accSum <= '0;
    else if (strobes.sumEn) accSum <= accNext;
  end

  // Round half up to the output fraction, then clamp
  always_comb begin
    rndSum = RND_W'(accSum) + RND_HALF;
    scaled = rndSum >>> SHIFT;
    if (scaled > OUT_MAX)      clampNext = OUT_MAX[OUT_W-1:0];
    else if (scaled < OUT_MIN) clampNext = OUT_MIN[OUT_W-1:0];
    else                       clampNext = scaled[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)                outData <= '0;
    else if (strobes.outEn) outData <= clampNext;
  end

  // R6: the line shifts by one position on an accepted sample
  assert_line_shift_R6: assert property (@(posedge clk) disable iff (rst)
    strobes.shiftEn |=> (taps[1] == $past(taps[0])));

  // R6: without an accepted sample the line does not move
  assert_line_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !strobes.shiftEn |=> ($stable(taps[0]) && $stable(taps[NUM_TAPS-1])));

  // R6: output register holds between results
  assert_out_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !strobes.outEn |=> $stable(outData));

  // R4: a positive exact sum never produces a negative output
  assert_no_wrap_pos_R4: assert property (@(posedge clk) disable iff (rst)
    (strobes.outEn && accSum > 0) |=> !outData[OUT_W-1]);

  // R4: a negative exact sum never produces a positive output
  assert_no_wrap_neg_R4: assert property (@(posedge clk) disable iff (rst)
    (strobes.outEn && accSum < 0) |=> (outData[OUT_W-1] || outData == '0));

  // R7: reset clears the output
  assert_reset_clear_R7: assert property (@(posedge clk)
    rst |=> (outData == '0));

endmodule

// File: rtl/mf_fir_top.sv
module mf_fir_top
  import mf_pkg::*;
#(
  parameter int NUM_TAPS  = 49,
  parameter int IN_W      = 16,
  parameter int IN_FRAC   = 14,
  parameter int COEF_W    = 16,
  parameter int COEF_FRAC = 15,
  parameter int OUT_W     = 18,
  parameter int OUT_FRAC  = 14,
  parameter logic signed [COEF_W-1:0] COEFS [(NUM_TAPS+1)/2] = DEF_COEFS
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    inValid,
  input  logic signed [IN_W-1:0]  inData,
  output logic                    outValid,
  output logic signed [OUT_W-1:0] outData
);

  stageStrobes_t strobes;

  mf_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  mf_datapath #(
    .NUM_TAPS  (NUM_TAPS),
    .IN_W      (IN_W),
    .IN_FRAC   (IN_FRAC),
    .COEF_W    (COEF_W),
    .COEF_FRAC (COEF_FRAC),
    .OUT_W     (OUT_W),
    .OUT_FRAC  (OUT_FRAC),
    .COEFS     (COEFS)
  ) datapath_i (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .inData  (inData),
    .outData (outData)
  );

  // R7: reset leaves no result pending
  assert_reset_valid_R7: assert property (@(posedge clk)
    rst |=> !outValid);

endmodule

// File: tb/mf_fir_top_tb_top.sv
module mf_fir_top_tb_top;
  import mf_pkg::*;

  localparam int TAPS  = 49;
  localparam int UNIQ  = (TAPS + 1) / 2;
  localparam int IN_W  = 16;
  localparam int OUT_W = 18;
  localparam int LAT   = 4;
  localparam int MAXQ  = 8192;
  localparam longint OMAX = 131071;
  localparam longint OMIN = -131072;

  // Stimulus table: value, repeat count, requirement code (1 = R1, 3 = R3)
  localparam int STIM_N = 11;
  localparam int stimVal [STIM_N] = '{16384, 0, -32768, 0, 1, 0, -1, 0, 32767, -20000, 0};
  localparam int stimRep [STIM_N] = '{1, 52, 1, 52, 1, 52, 1, 52, 8, 8, 52};
  localparam int stimReq [STIM_N] = '{1, 1, 1, 1, 3, 3, 3, 3, 3, 3, 3};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic signed [IN_W-1:0]  inData = '0;
  logic                    outValid;
  logic signed [OUT_W-1:0] outData;

  mf_fir_top dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .outValid(outValid), .outData(outData)
  );

  always #4 clk = ~clk;

  int     checks = 0;
  int     fails  = 0;
  longint cyc    = 0;
  string  curReq = "R7";
  int     hist   [TAPS];
  longint expQ   [MAXQ];
  longint capQ   [MAXQ];
  longint sendCyc[MAXQ];
  int     wrIdx = 0;
  int     rdIdx = 0;
  logic signed [OUT_W-1:0] lastOut = '0;
  logic [15:0] lfsr = 16'hACE1;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint coefAt(int k);
    return (k < UNIQ) ? longint'(DEF_COEFS[k]) : longint'(DEF_COEFS[TAPS-1-k]);
  endfunction

  function automatic longint modelOut();
    longint acc = 0;
    for (int k = 0; k < TAPS; k++) acc += coefAt(k) * longint'(hist[k]);
    acc = (acc + 16384) >>> 15;
    if (acc > OMAX) acc = OMAX;
    if (acc < OMIN) acc = OMIN;
    return acc;
  endfunction

  task automatic check(input bit ok, input string req, input longint act,
                       input longint exp, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic stepLfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic sendOne(input int v, input int gap);
    @(negedge clk);
    for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = v;
    expQ[wrIdx]    = modelOut();
    sendCyc[wrIdx] = cyc;
    wrIdx++;
    inValid = 1'b1;
    inData  = v[IN_W-1:0];
    if (gap > 0) begin
      @(negedge clk);
      inValid = 1'b0;
      repeat (gap - 1) @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    inValid = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    inValid = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R7", longint'(outValid), 0, "outValid in reset");
    check(outData == '0, "R7", longint'(outData), 0, "outData in reset");
    rdIdx = wrIdx;
    for (int k = 0; k < TAPS; k++) hist[k] = 0;
    rst = 1'b0;
  endtask

  // Output monitor: data, latency and hold behaviour
  always @(negedge clk) begin
    if (rst) begin
      lastOut <= outData;
    end else if (outValid) begin
      if (rdIdx >= wrIdx) begin
        check(1'b0, "R5", 1, 0, "unexpected outValid");
      end else begin
        check(longint'(outData) == expQ[rdIdx], curReq, longint'(outData), expQ[rdIdx], "output sample");
        check(cyc - sendCyc[rdIdx] == LAT + 1, "R5", cyc - sendCyc[rdIdx], LAT + 1, "latency");
        capQ[rdIdx] = longint'(outData);
        rdIdx++;
      end
      lastOut <= outData;
    end else begin
      check(outData == lastOut, "R6", longint'(outData), longint'(lastOut), "hold while idle");
    end
  end

  initial begin
    for (int k = 0; k < TAPS; k++) hist[k] = 0;
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog all-requirements: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int base;
    // R7: reset state
    repeat (5) @(negedge clk);
    check(outValid == 1'b0, "R7", longint'(outValid), 0, "outValid after power-up reset");
    check(outData == '0, "R7", longint'(outData), 0, "outData after power-up reset");
    rst = 1'b0;
    idle(3);

    // Table walk: impulses, rounding edges, steps (R1, R3, R2)
    for (int e = 0; e < STIM_N; e++) begin
      curReq = (stimReq[e] == 1) ? "R1" : "R3";
      for (int r = 0; r < stimRep[e]; r++) sendOne(stimVal[e], 0);
    end
    idle(10);

    // R1 and R2: direct impulse response and its mirror symmetry
    curReq = "R2";
    base = wrIdx;
    sendOne(16384, 0);
    for (int r = 0; r < TAPS - 1; r++) sendOne(0, 0);
    idle(10);
    for (int k = 0; k < TAPS; k++)
      check(capQ[base+k] == ((coefAt(k) + 1) >>> 1), "R1", capQ[base+k],
            (coefAt(k) + 1) >>> 1, "impulse tap");
    for (int k = 0; k < UNIQ; k++)
      check(capQ[base+k] == capQ[base+TAPS-1-k], "R2", capQ[base+k],
            capQ[base+TAPS-1-k], "impulse symmetry");

    // R4: sign-matched full-scale input drives both clamps
    curReq = "R4";
    for (int k = TAPS - 1; k >= 0; k--) sendOne((coefAt(k) >= 0) ? 32767 : -32768, 0);
    idle(10);
    check(capQ[wrIdx-1] == OMAX, "R4", capQ[wrIdx-1], OMAX, "positive clamp");
    for (int k = TAPS - 1; k >= 0; k--) sendOne((coefAt(k) >= 0) ? -32768 : 32767, 0);
    idle(10);
    check(capQ[wrIdx-1] == OMIN, "R4", capQ[wrIdx-1], OMIN, "negative clamp");

    // R8: random mapped bits, zero-stuffed to four samples per symbol
    curReq = "R8";
    for (int b = 0; b < 300; b++) begin
      stepLfsr();
      sendOne(lfsr[0] ? 16384 : -16384, 0);
      for (int z = 0; z < 3; z++) sendOne(0, 0);
    end
    idle(10);

    // R6 with R8: same kind of stream with idle gaps
    curReq = "R6";
    for (int b = 0; b < 100; b++) begin
      stepLfsr();
      sendOne(lfsr[0] ? 16384 : -16384, int'(lfsr[3:2]));
      for (int z = 0; z < 3; z++) begin
        stepLfsr();
        sendOne(0, int'(lfsr[2:1]));
      end
    end
    idle(10);

    // R7: reset in mid-stream, then an impulse against zero history
    curReq = "R7";
    for (int r = 0; r < 20; r++) sendOne(-20000 + r * 1500, 0);
    doReset();
    base = wrIdx;
    sendOne(16384, 0);
    for (int r = 0; r < 5; r++) sendOne(0, 0);
    idle(10);
    check(capQ[base] == ((coefAt(0) + 1) >>> 1), "R7", capQ[base],
          (coefAt(0) + 1) >>> 1, "first output after reset");
    check(rdIdx == wrIdx, "R5", rdIdx, wrIdx, "one output per input");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule